// File: doc/BRIEF.md
# Exposure-Aware Frame Timing Generator

This block produces the line and frame timing for the parallel video output of a rolling-shutter image sensor. It counts pixel clocks inside each line and lines inside each frame. From those counts it drives a frame sync, a line sync and a data-valid window. The host supplies the window height and width, the vertical blanking, the shutter time in lines, the line length, and the offsets that place the frame sync around the valid lines.

The number of lines in a frame is worked out again at each frame boundary. The base length is the window height, plus a fixed overhead of 20 lines, plus the vertical blanking. When the shutter time is longer than that base, the frame grows so that a long exposure fits inside it. Each frame takes its timing settings once, at its first cycle. The two sync polarities are live inputs and take effect at once.

Top module: `frame_timing_gen`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, the block is idle: frame sync inactive, line sync inactive, data_valid low and frame_lines zero. The first frame begins with line 0, pixel 0 in the cycle that follows.
- R2: Every line lasts exactly 2 × cfg_line_len pixel clocks. cfg_line_len must not be zero.
- R3: Frame length in lines is the minimum, cfg_win_height + 20 + VB, whenever cfg_shutter is less than or equal to that minimum. This holds at equality too. VB is the effective blanking from R5.
- R4: When cfg_shutter is strictly greater than the minimum frame length, the frame length is cfg_shutter + 16.
- R5: A cfg_vblank value below 16 is treated as 16 lines.
- R6: The frame sync is active from line 0 up to, but not including, line cfg_vs_start + cfg_win_height + cfg_vs_end. It is inactive for the remaining lines of the frame.
- R7: Valid lines are lines cfg_vs_start up to, but not including, cfg_vs_start + cfg_win_height. On a valid line, the line sync and data_valid are active for pixel clocks 0 to cfg_win_width − 1. They are inactive at every other time.
- R8: When cfg_vs_pol = 0 the frame sync is active-low; when it is 1 the frame sync is active-high. When cfg_hs_pol = 0 the line sync is active-high; when it is 1 the line sync is active-low. Both bits act in the same cycle they change.
- R9: All settings except the polarities are sampled only at a frame boundary. A change in the middle of a frame leaves frame_lines and the frame's timing unchanged until the next frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_win_height | input | 11 | Number of valid lines per frame |
| cfg_win_width | input | 12 | Number of valid pixel clocks per valid line |
| cfg_vblank | input | 14 | Vertical blanking in lines (minimum 16 applied) |
| cfg_shutter | input | 14 | Exposure time in lines |
| cfg_line_len | input | 12 | Line length in units of two pixel clocks |
| cfg_vs_start | input | 8 | Lines of frame sync before the first valid line |
| cfg_vs_end | input | 8 | Lines of frame sync after the last valid line |
| cfg_vs_pol | input | 1 | Frame sync polarity select (0 = active-low) |
| cfg_hs_pol | input | 1 | Line sync polarity select (0 = active-high) |
| vsync | output | 1 | Frame sync |
| hsync | output | 1 | Line sync |
| data_valid | output | 1 | High on the valid pixel clocks of valid lines |
| frame_lines | output | 16 | Line count of the current frame |

## Verification
The frame-length rule is tried with four kinds of settings:
- a short shutter, where the frame is the plain minimum;
- a shutter exactly equal to the minimum, which tells `>` apart from `>=`;
- a shutter one line longer than the minimum, and one well beyond it, where the extra 16 lines must appear;
- a blanking value below 16, which tells the clamp apart from a raw sum.

Settings are changed in the middle of frames, so a block that applies them early is caught. The polarity bits are flipped during a frame, so a polarity that is latched instead of live is also caught. A behavioural model of time since frame start is compared with every output on every clock. Directed probes check the edges of the valid window and the line period.

// File: rtl/frame_timing_gen.sv
module frame_timing_gen #(
  parameter int HGT_W  = 11,
  parameter int WID_W  = 12,
  parameter int VB_W   = 14,
  parameter int SHUT_W = 14,
  parameter int LEN_W  = 12,
  parameter int OFS_W  = 8,
  parameter int FL_W   = ((VB_W > SHUT_W ? VB_W : SHUT_W) > HGT_W ?
                          (VB_W > SHUT_W ? VB_W : SHUT_W) : HGT_W) + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HGT_W-1:0] cfg_win_height,
  input  logic [WID_W-1:0] cfg_win_width,
  input  logic [VB_W-1:0]  cfg_vblank,
  input  logic [SHUT_W-1:0] cfg_shutter,
  input  logic [LEN_W-1:0] cfg_line_len,
  input  logic [OFS_W-1:0] cfg_vs_start,
  input  logic [OFS_W-1:0] cfg_vs_end,
  input  logic             cfg_vs_pol,
  input  logic             cfg_hs_pol,
  output logic             vsync,
  output logic             hsync,
  output logic             data_valid,
  output logic [FL_W-1:0]  frame_lines
);

  localparam int PIX_W    = LEN_W + 1;
  localparam int OVERHEAD = 20;
  localparam int VB_MIN   = 16;
  localparam int EXP_PAD  = 16;

  logic             fresh_q;
  logic [PIX_W-1:0] pix_q;
  logic [FL_W-1:0]  line_q, flen_q;
  logic [HGT_W-1:0] h_q;
  logic [WID_W-1:0] w_q;
  logic [LEN_W-1:0] len_q;
  logic [OFS_W-1:0] st_q, et_q;

  // next frame length, evaluated from live inputs at the boundary
  logic [VB_W-1:0] vb_eff;
  logic [FL_W-1:0] min_len, flen_d;
  assign vb_eff  = (cfg_vblank < VB_W'(VB_MIN)) ? VB_W'(VB_MIN) : cfg_vblank;
  assign min_len = FL_W'(cfg_win_height) + FL_W'(OVERHEAD) + FL_W'(vb_eff);
  assign flen_d  = (FL_W'(cfg_shutter) > min_len) ?
                   FL_W'(cfg_shutter) + FL_W'(EXP_PAD) : min_len;

  logic [PIX_W-1:0] per;
  logic line_end, frame_end, load;
  assign per       = {len_q, 1'b0};
  assign line_end  = (pix_q == per - PIX_W'(1));
  assign frame_end = line_end && (line_q == flen_q - FL_W'(1));
  assign load      = fresh_q || frame_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fresh_q <= 1'b1;
      pix_q   <= '0;
      line_q  <= '0;
      flen_q  <= '0;
      h_q     <= '0;
      w_q     <= '0;
      len_q   <= '0;
      st_q    <= '0;
      et_q    <= '0;
    end else if (load) begin
      fresh_q <= 1'b0;
      pix_q   <= '0;
      line_q  <= '0;
      flen_q  <= flen_d;
      h_q     <= cfg_win_height;
      w_q     <= cfg_win_width;
      len_q   <= cfg_line_len;
      st_q    <= cfg_vs_start;
      et_q    <= cfg_vs_end;
    end else if (line_end) begin
      pix_q  <= '0;
      line_q <= line_q + FL_W'(1);
    end else begin
      pix_q  <= pix_q + PIX_W'(1);
    end
  end

  logic [FL_W-1:0] v_first, v_last, v_end;
  logic act_v, act_h;
  assign v_first = FL_W'(st_q);
  assign v_last  = v_first + FL_W'(h_q);
  assign v_end   = v_last + FL_W'(et_q);
  assign act_v   = !fresh_q && (line_q < v_end);
  assign act_h   = !fresh_q && (line_q >= v_first) && (line_q < v_last) &&
                   (pix_q < PIX_W'(w_q));

  assign vsync       = ~(act_v ^ cfg_vs_pol);
  assign hsync       = act_h ^ cfg_hs_pol;
  assign data_valid  = act_h;
  assign frame_lines = flen_q;

  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fresh_q |-> (!data_valid && frame_lines == '0));

  // R2
  pix_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fresh_q |-> (pix_q < per));

  // R3
  frame_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fresh_q |-> (flen_q >= FL_W'(h_q) + FL_W'(OVERHEAD + VB_MIN)));

  // R6
  valid_inside_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (vsync == cfg_vs_pol));

  // R7
  valid_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (pix_q < PIX_W'(w_q)));

  // R9
  frame_len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(frame_lines));

endmodule

// File: tb/frame_timing_gen_test.sv
`timescale 1ns/1ps
module frame_timing_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [10:0] cfg_win_height;
  logic [11:0] cfg_win_width;
  logic [13:0] cfg_vblank;
  logic [13:0] cfg_shutter;
  logic [11:0] cfg_line_len;
  logic [7:0]  cfg_vs_start, cfg_vs_end;
  logic        cfg_vs_pol, cfg_hs_pol;
  logic        vsync, hsync, data_valid;
  logic [15:0] frame_lines;

  always #2 clk = ~clk;

  frame_timing_gen uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_win_height(cfg_win_height), .cfg_win_width(cfg_win_width),
    .cfg_vblank(cfg_vblank), .cfg_shutter(cfg_shutter),
    .cfg_line_len(cfg_line_len), .cfg_vs_start(cfg_vs_start),
    .cfg_vs_end(cfg_vs_end), .cfg_vs_pol(cfg_vs_pol), .cfg_hs_pol(cfg_hs_pol),
    .vsync(vsync), .hsync(hsync), .data_valid(data_valid),
    .frame_lines(frame_lines)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // behavioural reference: time since frame start
  int m_fresh = 1, m_t = 0, m_flen = 0, m_per = 0, m_frames = 0;
  int m_h = 0, m_w = 0, m_st = 0, m_et = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fresh = 1; m_t = 0; m_flen = 0;
    end else if (m_fresh || m_t == m_flen * m_per - 1) begin
      int vb, mn;
      vb = (cfg_vblank < 16) ? 16 : int'(cfg_vblank);
      mn = int'(cfg_win_height) + 20 + vb;
      m_flen = (int'(cfg_shutter) > mn) ? int'(cfg_shutter) + 16 : mn;
      m_h = cfg_win_height; m_w = cfg_win_width;
      m_st = cfg_vs_start; m_et = cfg_vs_end;
      m_per = 2 * int'(cfg_line_len);
      m_t = 0; m_fresh = 0; m_frames++;
    end else begin
      m_t++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit av, ah, ev, eh;
      int ln, px;
      ln = (m_per > 0) ? m_t / m_per : 0;
      px = (m_per > 0) ? m_t % m_per : 0;
      av = !m_fresh && (ln < m_st + m_h + m_et);
      ah = !m_fresh && (ln >= m_st) && (ln < m_st + m_h) && (px < m_w);
      ev = cfg_vs_pol ? av : !av;
      eh = cfg_hs_pol ? !ah : ah;
      chk(vsync == ev, "R6 R8 vsync", vsync, ev);
      chk(hsync == eh, "R7 R8 hsync", hsync, eh);
      chk(data_valid == ah, "R7 data_valid", data_valid, ah);
      chk(int'(frame_lines) == m_flen, "R9 frame_lines", frame_lines, m_flen);
    end
  end

  task automatic wait_frame();
    int f = m_frames;
    while (m_frames == f) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    report();
  end

  initial begin
    cfg_win_height = 4; cfg_win_width = 12; cfg_vblank = 16; cfg_shutter = 10;
    cfg_line_len = 10; cfg_vs_start = 16; cfg_vs_end = 4;
    cfg_vs_pol = 0; cfg_hs_pol = 0;
    repeat (3) @(negedge clk);
    // R1: idle during reset
    chk(vsync == 1'b1, "R1 vsync idle", vsync, 1);
    chk(hsync == 1'b0, "R1 hsync idle", hsync, 0);
    chk(data_valid == 1'b0, "R1 data_valid idle", data_valid, 0);
    chk(frame_lines == 0, "R1 frame_lines idle", frame_lines, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: first frame 4+20+16
    chk(frame_lines == 40, "R3 min frame", frame_lines, 40);

    // R2: line period from one data_valid rise to the next
    begin
      int n = 0;
      while (!data_valid) @(negedge clk);
      while (data_valid) begin @(negedge clk); n++; end
      while (!data_valid) begin @(negedge clk); n++; end
      chk(n == 20, "R2 line period", n, 20);
    end

    // R9: mid-frame change is deferred
    cfg_shutter = 100;
    @(negedge clk);
    chk(frame_lines == 40, "R9 deferred", frame_lines, 40);
    wait_frame();
    chk(frame_lines == 116, "R4 long exposure", frame_lines, 116);

    cfg_shutter = 10; cfg_vblank = 5;
    wait_frame();
    chk(frame_lines == 40, "R5 vblank clamp", frame_lines, 40);

    cfg_vblank = 30;
    wait_frame();
    chk(frame_lines == 54, "R3 vblank sum", frame_lines, 54);

    cfg_shutter = 54;
    wait_frame();
    chk(frame_lines == 54, "R3 shutter equal", frame_lines, 54);

    cfg_shutter = 55;
    cfg_vs_pol = 1; cfg_hs_pol = 1;
    wait_frame();
    chk(frame_lines == 71, "R4 shutter above", frame_lines, 71);

    repeat (320) @(negedge clk);
    chk(hsync == 1'b0, "R8 hsync inverted active", hsync, 0);
    chk(vsync == 1'b1, "R8 vsync inverted active", vsync, 1);
    chk(data_valid == 1'b1, "R7 first valid pixel", data_valid, 1);
    repeat (11) @(negedge clk);
    chk(data_valid == 1'b1, "R7 last valid pixel", data_valid, 1);
    @(negedge clk);
    chk(data_valid == 1'b0, "R7 past width", data_valid, 0);
    chk(hsync == 1'b1, "R7 hsync blank", hsync, 1);
    repeat (147) @(negedge clk);
    chk(vsync == 1'b1, "R6 last sync line", vsync, 1);
    @(negedge clk);
    chk(vsync == 1'b0, "R6 sync end", vsync, 0);
    chk(data_valid == 1'b0, "R7 no valid after window", data_valid, 0);

    repeat (5) @(negedge clk);
    done = 1;
    report();
  end
endmodule